// File: doc/BRIEF.md
# Channel-Sliced Sample Packer

This block sits between a 16-line digital capture front end and a byte-wide FIFO bridge toward a host link. On each sample-enable pulse it takes one snapshot of the input bus. It then regroups the data by channel: every input line gets its own 16-bit word that holds that line's levels at 16 successive sample times. The result is a transposed layout, with one word per line, in place of one parallel word for each sample instant.

After the sixteenth sample of a group, the finished words are copied into a holding buffer. Capture of the next group can then go on while the buffered group drains. The buffer is emitted as bytes over a valid/ready handshake. Only the channels selected by an enable mask are sent, in ascending channel order, and each word is sent as two bytes. A group that finishes while the buffer still holds unsent bytes is discarded, and a sticky overflow flag is raised. The mask is taken at the start of each group, so the host can change it at any time without corrupting a group that is already being captured.

Top module: `chan_slice_packer`

## Requirements
- R1: After reset, out_valid and overflow are both 0.
- R2: In a channel's word, bit k holds the level of that channel at the k-th sample of the group, counting from 0. Bit 0 is the earliest sample and bit 15 the latest. A 1 means the input was high and a 0 means it was low.
- R3: Each channel word is sent as two bytes. The byte holding word bits 7..0 goes first, and the byte holding bits 15..8 goes second.
- R4: Within a group, words are sent only for channels whose mask bit is 1, from the lowest such channel up to the highest. The next group starts again at its lowest enabled channel.
- R5: A group produces exactly 2 bytes per enabled channel. This gives 6, 12, 18 and 32 bytes for the masks 0x0007, 0x003F, 0x01FF and 0xFFFF. Disabled channels produce no bytes.
- R6: Capture continues while the buffer drains. A group that completes when the buffer is empty is sent in full. This includes the case where the buffer's last byte is accepted in the same cycle that the group completes.
- R7: A group with a nonzero mask may complete while the buffer still holds at least one byte that has not been accepted. In that case the new group is dropped, and overflow goes to 1 in the next cycle and stays at 1 until reset. The buffered group is still sent unchanged.
- R8: The mask that applies to a group is the value of chan_mask at that group's first sample. Changes in chan_mask during later samples of the group take effect from the next group.
- R9: A group whose mask is 0 emits no bytes and does not raise overflow.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays at 1 and out_data holds its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Takes one snapshot of sample_in on this edge |
| sample_in | input | 16 | Input levels, one bit per channel |
| chan_mask | input | 16 | Channel enable mask, 1 = channel takes part |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | out_data holds a byte to be sent |
| out_data | output | 8 | Byte stream toward the bridge |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
The input patterns each tell a different class of fault apart:
- A walking one across the sample times shows whether the bit order is reversed or shifted.
- All-ones and alternating 0xAAAA/0x5555 patterns separate stuck bits from byte swaps.
- A pseudo-random stream separates channels that have been crossed with each other.

Each of the four supported masks is run with random data to check the order in which channels are skipped and the number of bytes per group.

Two mask cases check when the mask is taken. In one, the mask changes after a group's first sample. In the other, the mask is zero.

The remaining patterns load the holding buffer in different ways:
- Random backpressure checks that bytes are held while out_ready is low.
- Back-to-back groups at a spacing of exactly one drain time check the case where the buffer frees and reloads in the same cycle.
- A stalled output checks that the second group is dropped and that the overflow flag stays set.

// File: rtl/chan_pack_pkg.sv
package chan_pack_pkg;

   localparam int BYTE_W = 8;
   localparam int MAX_CH = 64;

   // Index of the lowest set bit, 0 when none is set.
   function automatic int unsigned first_one(input logic [MAX_CH-1:0] v);
      int unsigned r;
      r = 0;
      for (int i = MAX_CH - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/slice_capture.sv
module slice_capture #(
   parameter int NUM_CH  = 16,
   parameter int SAMPLES = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            sample_en,
   input  logic [NUM_CH-1:0]               sample_in,
   input  logic [NUM_CH-1:0]               chan_mask,
   output logic                            grp_done,
   output logic [NUM_CH-1:0][SAMPLES-1:0]  grp_words,
   output logic [NUM_CH-1:0]               grp_mask
);

   localparam int CNT_W = $clog2(SAMPLES);

   logic [CNT_W-1:0]  cnt;
   logic [NUM_CH-1:0] cur_mask;
   logic              at_last;
   logic              at_first;

   assign at_last  = (cnt == CNT_W'(SAMPLES - 1));
   assign at_first = (cnt == '0);
   assign grp_done = sample_en && at_last;
   assign grp_mask = cur_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cur_mask <= '0;
      end else if (sample_en) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
         if (at_first) cur_mask <= chan_mask;
      end
   end

   // One shift register per channel; newest sample enters at the top so
   // the earliest sample of the group ends up in bit 0.
   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [SAMPLES-1:0] shreg;
      logic [SAMPLES-1:0] shnext;

      assign shnext       = {sample_in[c], shreg[SAMPLES-1:1]};
      assign grp_words[c] = shnext;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         shreg <= '0;
         else if (sample_en) shreg <= shnext;
      end
   end

   // R2: the sample counter restarts after the last sample of a group
   assert_count_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && at_last) |=> (cnt == '0));

   // R8: the latched group mask cannot move once a group has begun
   assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(cur_mask));

endmodule

// File: rtl/slice_drain.sv
module slice_drain
   import chan_pack_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int SAMPLES = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_req,
   input  logic [NUM_CH-1:0][SAMPLES-1:0]  load_words,
   input  logic [NUM_CH-1:0]               load_mask,
   input  logic                            out_ready,
   output logic                            out_valid,
   output logic [BYTE_W-1:0]               out_data,
   output logic                            overflow
);

   localparam int BPW  = SAMPLES / BYTE_W;
   localparam int BI_W = (BPW > 1) ? $clog2(BPW) : 1;
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [NUM_CH-1:0][SAMPLES-1:0] hold;
   logic [NUM_CH-1:0]              pend;
   logic [NUM_CH-1:0]              pend_nxt;
   logic [CH_W-1:0]                cur;
   logic [BI_W-1:0]                bidx;
   logic [BI_W-1:0]                bidx_nxt;
   logic                           byte_last;
   logic                           fire;
   logic                           load_ok;
   logic                           load_take;
   logic                           load_drop;
   logic [SAMPLES-1:0]             word_sel;

   assign out_valid = (pend != '0);
   assign fire      = out_valid && out_ready;
   assign cur       = CH_W'(first_one(MAX_CH'(pend)));

   // Byte-index variant: a word that fits one byte needs no counter.
   if (BPW == 1) begin : g_one_byte
      assign byte_last = 1'b1;
      assign bidx_nxt  = '0;
   end else begin : g_multi_byte
      assign byte_last = (bidx == BI_W'(BPW - 1));
      assign bidx_nxt  = byte_last ? '0 : bidx + 1'b1;
   end

   always_comb begin
      pend_nxt = pend;
      if (fire && byte_last) pend_nxt[cur] = 1'b0;
   end

   assign load_ok   = load_req && (load_mask != '0);
   assign load_take = load_ok && (pend_nxt == '0);
   assign load_drop = load_ok && (pend_nxt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= '0;
         bidx     <= '0;
         overflow <= 1'b0;
      end else begin
         if (load_take) begin
            pend <= load_mask;
            bidx <= '0;
         end else begin
            pend <= pend_nxt;
            if (fire) bidx <= bidx_nxt;
         end
         if (load_drop) overflow <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (load_take) hold <= load_words;
   end

   always_comb begin
      word_sel = hold[cur];
      out_data = word_sel[bidx*BYTE_W +: BYTE_W];
   end

   // R10: a byte that was not accepted stays presented unchanged
   assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R7: the overflow flag never clears without reset
   assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R7: overflow only rises after a group completed
   assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(load_req));

   // R9: a zero-mask group does not start any output
   assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && (load_mask == '0) && !out_valid) |=> !out_valid);

   // R4: the stream only ends after a byte was accepted
   assert_end_by_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));

endmodule

// File: rtl/chan_slice_packer.sv
module chan_slice_packer
   import chan_pack_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int SAMPLES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic [NUM_CH-1:0]  sample_in,
   input  logic [NUM_CH-1:0]  chan_mask,
   input  logic               out_ready,
   output logic               out_valid,
   output logic [BYTE_W-1:0]  out_data,
   output logic               overflow
);

   if ((SAMPLES % BYTE_W) != 0 || SAMPLES < BYTE_W) begin : g_bad_samples
      $error("SAMPLES must be a nonzero multiple of the byte width");
   end
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_channels
      $error("NUM_CH out of supported range");
   end

   logic                           grp_done;
   logic [NUM_CH-1:0][SAMPLES-1:0] grp_words;
   logic [NUM_CH-1:0]              grp_mask;

   slice_capture #(
      .NUM_CH  (NUM_CH),
      .SAMPLES (SAMPLES)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .sample_in (sample_in),
      .chan_mask (chan_mask),
      .grp_done  (grp_done),
      .grp_words (grp_words),
      .grp_mask  (grp_mask)
   );

   slice_drain #(
      .NUM_CH  (NUM_CH),
      .SAMPLES (SAMPLES)
   ) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_req   (grp_done),
      .load_words (grp_words),
      .load_mask  (grp_mask),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .overflow   (overflow)
   );

endmodule

// File: tb/sim_chan_slice_packer.sv
module sim_chan_slice_packer;

   localparam int NS = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [15:0] sample_in = '0;
   logic [15:0] chan_mask = '0;
   logic        out_ready = 1'b0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        overflow;

   always #4 clk = ~clk;

   chan_slice_packer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .sample_in (sample_in),
      .chan_mask (chan_mask),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .overflow  (overflow)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;
   byte unsigned hq[$];
   logic [15:0] hist[$];
   logic [15:0] gmask = '0;
   bit          ov = 0;
   string       tag = "R1";
   logic [31:0] lfsr = 32'h1;

   function automatic logic [15:0] rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr[15:0];
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Build the expected bytes of a finished group from the recorded samples.
   task automatic build_group();
      for (int c = 0; c < 16; c++) begin
         if (gmask[c]) begin
            logic [15:0] w;
            for (int k = 0; k < NS; k++) w[k] = hist[k][c];
            hq.push_back(w[7:0]);
            hq.push_back(w[15:8]);
         end
      end
   endtask

   task automatic step(bit en, logic [15:0] smp, logic [15:0] msk, bit rdy);
      bit ev;
      sample_en = en;
      sample_in = smp;
      chan_mask = msk;
      out_ready = rdy;
      #1;
      ev = (hq.size() != 0);
      check(out_valid === ev, tag, "out_valid", int'(out_valid), int'(ev));
      if (ev)
         check(out_data === hq[0], tag, "out_data", int'(out_data), int'(hq[0]));
      check(overflow === ov, tag, "overflow", int'(overflow), int'(ov));
      if (ev && rdy) void'(hq.pop_front());
      if (en) begin
         if (hist.size() == 0) gmask = msk;
         hist.push_back(smp);
         if (hist.size() == NS) begin
            if (gmask != '0) begin
               if (hq.size() == 0) build_group();
               else ov = 1;
            end
            hist.delete();
         end
      end
      @(posedge clk);
      #2;
   endtask

   function automatic bit pick_ready(int rmode);
      if (rmode == 0) return 1'b1;
      if (rmode == 1) return 1'b0;
      return rnd() [3];
   endfunction

   // kind: 0 walking one, 1 all ones, 2 alternating, 3 pseudo-random
   task automatic run_group(int kind, logic [15:0] m_first, logic [15:0] m_rest,
                            int gap, int rmode);
      for (int k = 0; k < NS; k++) begin
         logic [15:0] s;
         case (kind)
            0: s = 16'h1 << k;
            1: s = 16'hFFFF;
            2: s = k[0] ? 16'h5555 : 16'hAAAA;
            default: s = rnd();
         endcase
         step(1'b1, s, (k == 0) ? m_first : m_rest, pick_ready(rmode));
         for (int g = 0; g < gap; g++) step(1'b0, rnd(), m_rest, pick_ready(rmode));
      end
   endtask

   task automatic idle(int n, logic [15:0] msk);
      for (int i = 0; i < n; i++) step(1'b0, rnd(), msk, 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
      check(overflow === 1'b0, "R1", "overflow after reset", int'(overflow), 0);
      rst_n = 1'b1;

      tag = "R2";
      run_group(0, 16'hFFFF, 16'hFFFF, 2, 0);
      idle(40, 16'hFFFF);
      tag = "R3";
      run_group(1, 16'hFFFF, 16'hFFFF, 2, 0);
      run_group(2, 16'hFFFF, 16'hFFFF, 2, 0);
      run_group(3, 16'hFFFF, 16'hFFFF, 2, 0);
      idle(40, 16'hFFFF);

      tag = "R4";
      run_group(3, 16'h0007, 16'h0007, 0, 0);
      run_group(3, 16'h0007, 16'h0007, 0, 0);
      idle(10, 16'h0007);
      tag = "R5";
      run_group(3, 16'h003F, 16'h003F, 0, 0);
      idle(16, 16'h003F);
      run_group(3, 16'h01FF, 16'h01FF, 1, 0);
      idle(24, 16'h01FF);

      tag = "R9";
      run_group(3, 16'h0000, 16'h0000, 0, 0);
      run_group(3, 16'h0000, 16'h0000, 1, 0);
      idle(4, 16'h0000);
      check(overflow === 1'b0, "R9", "overflow after zero-mask groups", int'(overflow), 0);

      tag = "R8";
      run_group(3, 16'hFFFF, 16'h0007, 2, 0);
      idle(40, 16'h0007);
      run_group(3, 16'h0007, 16'hFFFF, 0, 0);
      run_group(3, 16'h0000, 16'hFFFF, 0, 0);
      idle(10, 16'hFFFF);

      tag = "R10";
      run_group(3, 16'hFFFF, 16'hFFFF, 5, 2);
      run_group(3, 16'h003F, 16'h003F, 5, 2);
      idle(80, 16'hFFFF);

      tag = "R6";
      run_group(3, 16'hFFFF, 16'hFFFF, 1, 0);
      run_group(3, 16'hFFFF, 16'hFFFF, 1, 0);
      run_group(3, 16'hFFFF, 16'hFFFF, 1, 0);
      idle(40, 16'hFFFF);
      check(overflow === 1'b0, "R6", "overflow after back-to-back groups", int'(overflow), 0);

      tag = "R7";
      run_group(3, 16'h0007, 16'h0007, 0, 1);
      run_group(3, 16'h0007, 16'h0007, 0, 1);
      step(1'b0, 16'h0, 16'h0007, 1'b0);
      check(overflow === 1'b1, "R7", "overflow after dropped group", int'(overflow), 1);
      idle(20, 16'h0007);
      check(overflow === 1'b1, "R7", "overflow still set", int'(overflow), 1);

      finish_run();
   end

endmodule